// File: doc/BRIEF.md
# Dynamic Loss Scale Controller

This block keeps the loss scale of a low-precision training loop, so that small gradients stay representable in 16-bit half-precision words. The scale is always a power of two and is held only as a signed exponent. Downstream logic multiplies the loss by two to the power of `scale_exp` and later divides the gradients by the same factor. The multiplication, the gradients and the optimizer all lie outside this block.

While an iteration runs, every valid half-precision gradient word is examined. A word whose 5-bit exponent field, bits 14 down to 10, is all ones is infinity or NaN, and it marks the iteration as overflowed. On the end-of-iteration strobe the block makes its decision. After an overflow it withholds the weight update with a skip pulse, lowers the exponent by one and restarts the clean-run count. After a clean iteration it allows the update with a commit pulse. Once a configured number of clean iterations in a row has been seen, it raises the exponent by one. Two saturating counters record the skipped iterations and the total iterations.

Top module: `loss_scale_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `scale_exp` loads `cfg_init_exp` after that edge, and both pulses and both counters read zero.
- R2: A word accepted with `grad_valid` high counts as an overflow exactly when bits [14:10] are all ones. The sign bit [15] and the mantissa bits [9:0] have no effect on this, and any word with another exponent value is finite.
- R3: For each cycle in which `iter_end` is high, exactly one of `commit_pulse` and `skip_pulse` is high for one cycle in the next cycle. Neither pulse appears at any other time, and `scale_exp` changes only in a cycle that carries a pulse.
- R4: When an iteration overflows, the block raises `skip_pulse` and lowers `scale_exp` by one. If `scale_exp` is already at or below `cfg_min_exp`, it holds instead.
- R5: When the clean-run count reaches `cfg_grow_len`, counting the current iteration (a value of 0 acts as 1), `scale_exp` rises by one and the count restarts at zero. If `scale_exp` is already at or above `cfg_max_exp`, it holds, and the count still restarts.
- R6: An overflowed iteration sets the clean-run count to zero, so a scale increase needs `cfg_grow_len` clean iterations after the last overflow.
- R7: The overflow mark covers the words from the first cycle after the previous strobe up to and including the cycle of the current strobe. A bad word in the strobe cycle counts toward the iteration that is ending, and it does not carry into the next one.
- R8: `skip_count` counts skip pulses and `iter_count` counts strobes. Both stop at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_init_exp | input | EXP_W | Starting scale exponent, signed |
| cfg_min_exp | input | EXP_W | Lowest allowed exponent, signed |
| cfg_max_exp | input | EXP_W | Highest allowed exponent, signed |
| cfg_grow_len | input | RUN_W | Clean iterations needed before the scale is raised |
| grad_valid | input | 1 | `grad_word` holds a gradient this cycle |
| grad_word | input | 16 | Half-precision gradient word |
| iter_end | input | 1 | End-of-iteration strobe |
| scale_exp | output | EXP_W | Current scale exponent, signed |
| commit_pulse | output | 1 | Weight update allowed for the iteration that just ended |
| skip_pulse | output | 1 | Weight update withheld for the iteration that just ended |
| skip_count | output | STAT_W | Saturating count of skipped iterations |
| iter_count | output | STAT_W | Saturating count of all iterations |

## Verification
The bench goes after the half-precision word classes that sit at the boundary. The largest finite word must commit, and negative infinity and a negative NaN must skip. A detector that looked at the mantissa or the sign would commit on one of these or skip on the other. It also places a bad word in the same cycle as the strobe. A design that lost that word would commit; one that kept it in the sticky mark would wrongly skip the next clean iteration. It drives the exponent into both clamps and watches the run counter at the top. A missing clamp shows up as an exponent that moves past a limit, an off-by-one in the run compare doubles one iteration early or late, and a missing counter reset after an overflow doubles too soon. The counters are pushed past their limit, where a wrapping counter would read zero.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int HALF_W = 16;
  // bits that are not part of the 5-bit exponent field [14:10]
  localparam logic [HALF_W-1:0] NON_EXP_MASK = 16'h83FF;

  // infinity or NaN: exponent field all ones, sign and mantissa ignored
  function automatic logic half_nonfinite(input logic [HALF_W-1:0] w);
    return &(w | NON_EXP_MASK);
  endfunction

  typedef enum logic [1:0] {
    VERDICT_NONE   = 2'b00,
    VERDICT_COMMIT = 2'b01,
    VERDICT_SKIP   = 2'b10
  } verdict_t;
endpackage

// File: rtl/lsc_ovf_sticky.sv
module lsc_ovf_sticky
  import lsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              grad_valid,
  input  logic [HALF_W-1:0] grad_word,
  input  logic              iter_end,
  output logic              iter_ovf
);
  logic sticky_q;
  logic word_bad;

  assign word_bad = grad_valid && half_nonfinite(grad_word);
  // includes the word that arrives alongside the strobe
  assign iter_ovf = sticky_q || word_bad;

  always_ff @(posedge clk) begin
    if (rst)           sticky_q <= 1'b0;
    else if (iter_end) sticky_q <= 1'b0;
    else if (word_bad) sticky_q <= 1'b1;
  end
endmodule

// File: rtl/lsc_scale_ctrl.sv
module lsc_scale_ctrl
  import lsc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int RUN_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [EXP_W-1:0] cfg_init_exp,
  input  logic signed [EXP_W-1:0] cfg_min_exp,
  input  logic signed [EXP_W-1:0] cfg_max_exp,
  input  logic        [RUN_W-1:0] cfg_grow_len,
  input  logic                    iter_end,
  input  logic                    iter_ovf,
  output logic signed [EXP_W-1:0] scale_exp,
  output verdict_t                verdict
);
  localparam int RUN_XW = RUN_W + 1;

  logic [RUN_W-1:0]  clean_q;
  logic [RUN_XW-1:0] clean_inc;
  logic              run_done;
  logic              can_dec;
  logic              can_inc;

  assign clean_inc = {1'b0, clean_q} + RUN_XW'(1);
  assign run_done  = clean_inc >= {1'b0, cfg_grow_len};
  assign can_dec   = scale_exp > cfg_min_exp;
  assign can_inc   = scale_exp < cfg_max_exp;

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_exp <= cfg_init_exp;
      clean_q   <= '0;
      verdict   <= VERDICT_NONE;
    end else if (iter_end) begin
      if (iter_ovf) begin
        verdict <= VERDICT_SKIP;
        clean_q <= '0;
        if (can_dec) scale_exp <= scale_exp - EXP_W'(1);
      end else begin
        verdict <= VERDICT_COMMIT;
        if (run_done) begin
          clean_q <= '0;
          if (can_inc) scale_exp <= scale_exp + EXP_W'(1);
        end else begin
          clean_q <= clean_inc[RUN_W-1:0];
        end
      end
    end else begin
      verdict <= VERDICT_NONE;
    end
  end
endmodule

// File: rtl/lsc_sat_cnt.sv
module lsc_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bump,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                  count <= '0;
    else if (bump && !(&count)) count <= count + W'(1);
  end
endmodule

// File: rtl/loss_scale_ctrl.sv
module loss_scale_ctrl
  import lsc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int RUN_W  = 16,
  parameter int STAT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [EXP_W-1:0] cfg_init_exp,
  input  logic signed [EXP_W-1:0] cfg_min_exp,
  input  logic signed [EXP_W-1:0] cfg_max_exp,
  input  logic        [RUN_W-1:0] cfg_grow_len,
  input  logic                    grad_valid,
  input  logic [15:0]             grad_word,
  input  logic                    iter_end,
  output logic signed [EXP_W-1:0] scale_exp,
  output logic                    commit_pulse,
  output logic                    skip_pulse,
  output logic [STAT_W-1:0]       skip_count,
  output logic [STAT_W-1:0]       iter_count
);
  localparam int N_STATS = 2;

  logic     iter_ovf;
  verdict_t verdict;
  logic [N_STATS-1:0]             stat_bump;
  logic [N_STATS-1:0][STAT_W-1:0] stat_val;

  lsc_ovf_sticky u_sticky (
    .clk        (clk),
    .rst        (rst),
    .grad_valid (grad_valid),
    .grad_word  (grad_word),
    .iter_end   (iter_end),
    .iter_ovf   (iter_ovf)
  );

  lsc_scale_ctrl #(
    .EXP_W (EXP_W),
    .RUN_W (RUN_W)
  ) u_scale (
    .clk          (clk),
    .rst          (rst),
    .cfg_init_exp (cfg_init_exp),
    .cfg_min_exp  (cfg_min_exp),
    .cfg_max_exp  (cfg_max_exp),
    .cfg_grow_len (cfg_grow_len),
    .iter_end     (iter_end),
    .iter_ovf     (iter_ovf),
    .scale_exp    (scale_exp),
    .verdict      (verdict)
  );

  assign commit_pulse = (verdict == VERDICT_COMMIT);
  assign skip_pulse   = (verdict == VERDICT_SKIP);

  // counters bump in the same cycle as the verdict register
  assign stat_bump[0] = iter_end && iter_ovf;
  assign stat_bump[1] = iter_end;

  for (genvar g = 0; g < N_STATS; g++) begin : g_stat
    lsc_sat_cnt #(.W(STAT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .bump  (stat_bump[g]),
      .count (stat_val[g])
    );
  end

  assign skip_count = stat_val[0];
  assign iter_count = stat_val[1];
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int EXP_W  = 8,
  parameter int STAT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    iter_end,
  input logic signed [EXP_W-1:0] cfg_min_exp,
  input logic signed [EXP_W-1:0] scale_exp,
  input logic                    commit_pulse,
  input logic                    skip_pulse,
  input logic [STAT_W-1:0]       skip_count,
  input logic [STAT_W-1:0]       iter_count
);
  logic rst_q = 1'b1;
  always_ff @(posedge clk) rst_q <= rst;

  // R3
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit_pulse && skip_pulse));

  // R3
  end_gives_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    iter_end |=> (commit_pulse || skip_pulse));

  // R3
  pulse_needs_end_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    (commit_pulse || skip_pulse) |-> $past(iter_end));

  // R3
  scale_moves_with_pulse_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    (scale_exp != $past(scale_exp)) |-> (commit_pulse || skip_pulse));

  // R4
  skip_lowers_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    (skip_pulse && ($past(scale_exp) > cfg_min_exp)) |-> (scale_exp == $past(scale_exp) - EXP_W'(1)));

  // R5
  rise_only_on_commit_chk: assert property (@(posedge clk) disable iff (rst || rst_q)
    (scale_exp > $past(scale_exp)) |-> commit_pulse);

  // R8
  skip_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (&skip_count) |=> (&skip_count));

  // R8
  iter_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (&iter_count) |=> (&iter_count));
endmodule

bind loss_scale_ctrl lsc_checker #(
  .EXP_W  (EXP_W),
  .STAT_W (STAT_W)
) u_lsc_checker (
  .clk          (clk),
  .rst          (rst),
  .iter_end     (iter_end),
  .cfg_min_exp  (cfg_min_exp),
  .scale_exp    (scale_exp),
  .commit_pulse (commit_pulse),
  .skip_pulse   (skip_pulse),
  .skip_count   (skip_count),
  .iter_count   (iter_count)
);

// File: tb/loss_scale_ctrl_bench.sv
`timescale 1ns/1ps
module loss_scale_ctrl_bench;
  localparam int EXP_W  = 8;
  localparam int RUN_W  = 16;
  localparam int STAT_W = 6;
  localparam int STAT_MAX = (1 << STAT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [EXP_W-1:0] cfg_init_exp = 8'sd4;
  logic signed [EXP_W-1:0] cfg_min_exp  = -8'sd2;
  logic signed [EXP_W-1:0] cfg_max_exp  = 8'sd6;
  logic [RUN_W-1:0] cfg_grow_len = 16'd3;
  logic grad_valid = 1'b0;
  logic [15:0] grad_word = '0;
  logic iter_end = 1'b0;
  logic signed [EXP_W-1:0] scale_exp;
  logic commit_pulse, skip_pulse;
  logic [STAT_W-1:0] skip_count, iter_count;

  int checks = 0;
  int errors = 0;

  // bench model of the requirements
  int m_exp, m_clean, m_skips, m_iters;
  bit m_sticky, m_commit, m_skip;

  always #2.5 clk = ~clk;

  loss_scale_ctrl #(.EXP_W(EXP_W), .RUN_W(RUN_W), .STAT_W(STAT_W)) u_loss_scale_ctrl (
    .clk(clk), .rst(rst),
    .cfg_init_exp(cfg_init_exp), .cfg_min_exp(cfg_min_exp), .cfg_max_exp(cfg_max_exp),
    .cfg_grow_len(cfg_grow_len), .grad_valid(grad_valid), .grad_word(grad_word),
    .iter_end(iter_end), .scale_exp(scale_exp), .commit_pulse(commit_pulse),
    .skip_pulse(skip_pulse), .skip_count(skip_count), .iter_count(iter_count)
  );

  function automatic bit word_bad(input logic [15:0] w);
    return w[14:10] == 5'b11111;  // R2
  endfunction

  function automatic int sat_inc(input int v);
    return (v < STAT_MAX) ? v + 1 : v;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (scale_exp !== EXP_W'(m_exp) || commit_pulse !== m_commit || skip_pulse !== m_skip ||
        skip_count !== STAT_W'(m_skips) || iter_count !== STAT_W'(m_iters)) begin
      errors++;
      $display("FAIL %s scale=%0d/%0d commit=%0b/%0b skip=%0b/%0b skips=%0d/%0d iters=%0d/%0d",
               tag, scale_exp, m_exp, commit_pulse, m_commit, skip_pulse, m_skip,
               skip_count, m_skips, iter_count, m_iters);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; grad_valid = 1'b0; iter_end = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    m_exp = int'(cfg_init_exp); m_clean = 0; m_skips = 0; m_iters = 0;
    m_sticky = 0; m_commit = 0; m_skip = 0;
    compare(tag);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic step(input bit v, input logic [15:0] w, input bit e, input string tag);
    bit ovf;
    int grow;
    @(negedge clk);
    grad_valid = v; grad_word = w; iter_end = e;
    @(posedge clk); #1;
    ovf = m_sticky || (v && word_bad(w));
    grow = (cfg_grow_len == 0) ? 1 : int'(cfg_grow_len);
    m_commit = 0; m_skip = 0;
    if (e) begin
      m_iters = sat_inc(m_iters);
      m_sticky = 0;
      if (ovf) begin
        m_skip = 1; m_skips = sat_inc(m_skips); m_clean = 0;
        if (m_exp > int'(cfg_min_exp)) m_exp--;
      end else begin
        m_commit = 1;
        if (m_clean + 1 >= grow) begin
          m_clean = 0;
          if (m_exp < int'(cfg_max_exp)) m_exp++;
        end else m_clean++;
      end
    end else m_sticky = ovf;
    compare(tag);
  endtask

  // one iteration: a word then the strobe with an idle cycle
  task automatic iter(input logic [15:0] w, input string tag);
    step(1'b1, w, 1'b0, tag);
    step(1'b0, 16'h0000, 1'b1, tag);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset("R1 reset state");

    iter(16'h3C00, "R3 clean iteration commits");
    step(1'b1, 16'h4000, 1'b0, "R3 no pulse without strobe");
    step(1'b0, 16'h0000, 1'b1, "R3 commit");
    iter(16'h7C00, "R2 R4 +inf skips and lowers");
    iter(16'hFE01, "R2 negative NaN skips");
    iter(16'h7BFF, "R2 largest finite commits");
    iter(16'hFC00, "R2 -inf skips");
    iter(16'h1234, "R5 clean 1");
    iter(16'h0001, "R5 clean 2");
    iter(16'h8000, "R5 clean 3 raises scale");
    iter(16'h3C00, "R6 clean 1");
    iter(16'h3C00, "R6 clean 2");
    iter(16'h7C01, "R6 overflow restarts run");
    iter(16'h3C00, "R6 clean 1 after overflow");
    iter(16'h3C00, "R6 clean 2 no raise yet");
    iter(16'h3C00, "R6 clean 3 raises");
    step(1'b1, 16'h7E00, 1'b1, "R7 bad word with strobe skips");
    step(1'b0, 16'h0000, 1'b1, "R7 next iteration clean");
    step(1'b0, 16'h0000, 1'b0, "R7 idle");

    for (int i = 0; i < 12; i++) iter(16'h7C00, "R4 clamp at minimum");
    for (int i = 0; i < 40; i++) iter(16'h3C00, "R5 clamp at maximum");

    cfg_grow_len = 16'd0;
    do_reset("R1 reset with grow length zero");
    for (int i = 0; i < 4; i++) iter(16'h2000, "R5 grow length zero raises each");

    cfg_grow_len = 16'd3;
    do_reset("R1 reset before saturation");
    for (int i = 0; i < STAT_MAX + 7; i++) step(1'b1, 16'hFC00, 1'b1, "R8 counters saturate");
    checks++;
    if (skip_count !== STAT_W'(STAT_MAX) || iter_count !== STAT_W'(STAT_MAX)) begin
      errors++;
      $display("FAIL R8 skips=%0d iters=%0d expected %0d", skip_count, iter_count, STAT_MAX);
    end

    cfg_init_exp = 8'sd0; cfg_min_exp = -8'sd5; cfg_max_exp = 8'sd5; cfg_grow_len = 16'd2;
    do_reset("R1 reset before random run");
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if ($urandom % 10 == 0) w[14:10] = 5'b11111;
      else if (w[14:10] == 5'b11111) w[14] = 1'b0;
      step(($urandom % 3) != 0, w, ($urandom % 5) == 0, "R2 R3 R4 R5 R6 R7 random");
    end

    step(1'b0, 16'h0000, 1'b0, "R3 final idle");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule